// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block places a small one-word-per-line cache between a CPU request port and a word-addressed main memory. The CPU address is split into a line index (low bits) and a tag (high bits). Each line keeps a valid flag, a stored tag and one data word. A read that finds a valid line with a matching tag is answered from the cache one cycle after it is accepted. Any other read goes out to main memory. The returned word is passed to the CPU and is also loaded into the line together with the new tag.

Every write takes the same path, whether it hits or misses. The write data and tag are placed in the indexed line, the line is marked valid, and the same word is sent to main memory. The CPU sees ready only once memory has acknowledged. Addresses that share an index compete for one line, so each access evicts whatever that line held before. Two counters report how many accepted accesses hit and how many missed.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid, `ready_o` and `mem_req_o` are low and both counters are zero.
- R2: The line index is `addr_i[IDX_W-1:0]` and the tag is the remaining upper address bits. With the defaults, index = addr[2:0] and tag = addr[4:3].
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. An invalid line misses even when its stored tag (reset value 0) matches.
- R4: A read hit raises `ready_o` in the cycle after the request is accepted, returns the cached word on `rdata_o` and issues no memory request.
- R5: A read miss issues a memory read of `addr_i`. The word memory returns appears on `rdata_o` with `ready_o`, and it is loaded into the line so that the next read of that address hits.
- R6: Every write issues a memory write of `wdata_i` to `addr_i`, whether it hits or misses. The line takes the data and tag and becomes valid, so a later read of that address hits and returns the written word.
- R7: An access to an address that shares an index but has a different tag replaces the line, and the previously cached address then misses.
- R8: `ready_o` is a single-cycle pulse per request. `mem_req_o`, `mem_addr_o` and `mem_we_o` hold steady until `mem_ready_i` is seen.
- R9: Each accepted access adds one to `hit_cnt_o` if it hits, or one to `miss_cnt_o` if it misses. This applies to reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | CPU request; held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | CPU word address |
| wdata_i | input | DATA_W | CPU write data |
| rdata_o | output | DATA_W | Read data, valid with `ready_o` |
| ready_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with `mem_ready_i` |
| mem_ready_i | input | 1 | Memory completion |
| hit_cnt_o | output | CNT_W | Accesses that hit |
| miss_cnt_o | output | CNT_W | Accesses that missed |

## Verification
The bench uses the default parameters: a 5-bit address, 8 lines, 16-bit data and 16-bit counters. It adds a 32-word memory model that acknowledges each request two cycles after it arrives. At this size every main-memory word can be visited. The bench sweeps the whole address space so that each line is evicted by all four tags in turn. It also exercises the reset case, where a zero tag matches an invalid line. Write hits and write misses are both checked against the memory model's contents.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  localparam int LINES = 1 << IDX_W;

  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag_i;
      end
    end
  end

  assign hit_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);

  AST_FILL_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)] && (tag_q[$past(wr_idx_i)] == $past(wr_tag_i))); // R6
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic hit_i,
  input  logic mem_ready_i,
  output logic accept_o,
  output logic fast_o,
  output logic fill_o,
  output logic mem_req_o,
  output logic ready_o
);
  dmc_state_e state_q, state_d;

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign fast_o    = accept_o && !we_i && hit_i;
  assign fill_o    = (state_q == ST_MEM) && mem_ready_i;
  assign mem_req_o = (state_q == ST_MEM);
  assign ready_o   = (state_q == ST_RESP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = fast_o ? ST_RESP : ST_MEM;
      ST_MEM:  if (mem_ready_i) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R8
  AST_FAST_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |=> ready_o && !mem_req_o); // R4
  AST_SLOW_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !fast_o) |=> mem_req_o); // R5
endmodule

// File: rtl/dmc_perf_cnt.sv
module dmc_perf_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_inc_i,
  input  logic             miss_inc_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (hit_inc_i)  hit_cnt_o  <= hit_cnt_o + 1'b1;
      if (miss_inc_i) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              hit, accept, fast, fill;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, line_data, fill_data;

  wire [IDX_W-1:0] idx_in  = addr_i[IDX_W-1:0];
  wire [TAG_W-1:0] tag_in  = addr_i[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] idx_req = addr_q[IDX_W-1:0];
  wire [TAG_W-1:0] tag_req = addr_q[ADDR_W-1:IDX_W];

  assign fill_data = we_q ? wdata_q : mem_rdata_i;

  dmc_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .hit_i       (hit),
    .mem_ready_i (mem_ready_i),
    .accept_o    (accept),
    .fast_o      (fast),
    .fill_o      (fill),
    .mem_req_o   (mem_req_o),
    .ready_o     (ready_o)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (idx_in),
    .rd_tag_i (tag_in),
    .hit_o    (hit),
    .wr_en_i  (fill),
    .wr_idx_i (idx_req),
    .wr_tag_i (tag_req)
  );

  dmc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_data (
    .clk_i     (clk_i),
    .rd_idx_i  (idx_in),
    .rd_data_o (line_data),
    .wr_en_i   (fill),
    .wr_idx_i  (idx_req),
    .wr_data_i (fill_data)
  );

  dmc_perf_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_inc_i  (accept && hit),
    .miss_inc_i (accept && !hit),
    .hit_cnt_o  (hit_cnt_o),
    .miss_cnt_o (miss_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        we_q    <= we_i;
        wdata_q <= wdata_i;
      end
      if (fast)      rdata_q <= line_data;
      else if (fill) rdata_q <= fill_data;
    end
  end

  assign rdata_o     = rdata_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  AST_MEM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R8
  AST_WRITE_GOES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && we_i) |=> mem_req_o && mem_we_o && (mem_wdata_o == $past(wdata_i))); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> CNT_W'(hit_cnt_o + miss_cnt_o) == CNT_W'($past(hit_cnt_o) + $past(miss_cnt_o) + 1'b1)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !ready_o && !mem_req_o); // R1
endmodule

// File: tb/test_dm_wt_cache.sv
module test_dm_wt_cache;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int MEM_LAT = 2;

  typedef struct {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              hit;
    int                hits;
    int                misses;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o, mem_wdata_o, mem_rdata_i;
  logic ready_o, mem_req_o, mem_we_o, mem_ready_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [CNT_W-1:0] hit_cnt_o, miss_cnt_o;

  always #2.5 clk_i = ~clk_i;

  dm_wt_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_dm_wt_cache (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ready_i,
    .hit_cnt_o, .miss_cnt_o
  );

  // memory model
  logic [DATA_W-1:0] ram [WORDS];
  logic [DATA_W-1:0] shadow_mem [WORDS];
  int lat_cnt = 0;
  logic mem_rdy_q = 1'b0;
  logic [DATA_W-1:0] mem_rd_q = '0;
  assign mem_ready_i = mem_rdy_q;
  assign mem_rdata_i = mem_rd_q;

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      ram[i] = DATA_W'(16'h1000 + i * 16'h0111);
      shadow_mem[i] = ram[i];
    end
  end

  always @(posedge clk_i) begin
    mem_rdy_q <= 1'b0;
    if (mem_req_o && !mem_rdy_q) begin
      if (lat_cnt == MEM_LAT - 1) begin
        lat_cnt <= 0;
        mem_rdy_q <= 1'b1;
        if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
        else mem_rd_q <= ram[mem_addr_o];
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  int checks = 0, failures = 0;
  item_t sb_q [$];
  logic sh_valid [LINES];
  logic [ADDR_W-IDX_W-1:0] sh_tag [LINES];
  int exp_hits = 0, exp_misses = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: predicts and queues, then drives
  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    item_t it;
    logic [IDX_W-1:0] idx = a[IDX_W-1:0];
    logic [ADDR_W-IDX_W-1:0] tg = a[ADDR_W-1:IDX_W];
    it.we = we; it.addr = a;
    it.hit = sh_valid[idx] && (sh_tag[idx] == tg);
    if (it.hit) exp_hits++; else exp_misses++;
    it.data = we ? d : shadow_mem[a];
    if (we) shadow_mem[a] = d;
    sh_valid[idx] = 1'b1;
    sh_tag[idx] = tg;
    it.hits = exp_hits; it.misses = exp_misses;
    sb_q.push_back(it);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    do @(negedge clk_i); while (!ready_o);
    req_i = 1'b0;
  endtask

  // monitor
  logic saw_mem = 1'b0, prev_ready = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_req_o) saw_mem = 1'b1;
      if (ready_o) begin
        item_t it;
        chk(!prev_ready, "R8", "ready pulse width", 32'(prev_ready), 32'd0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected ready", 32'd1, 32'd0);
        end else begin
          it = sb_q.pop_front();
          chk(saw_mem == (it.we || !it.hit), "R3", "memory used on hit/miss",
              32'(saw_mem), 32'(it.we || !it.hit));
          if (!it.we)
            chk(rdata_o == it.data, it.hit ? "R4" : "R5", "read data", 32'(rdata_o), 32'(it.data));
          else
            chk(ram[it.addr] == it.data, "R6", "write-through memory word",
                32'(ram[it.addr]), 32'(it.data));
          chk(hit_cnt_o == CNT_W'(it.hits), "R9", "hit counter", 32'(hit_cnt_o), 32'(it.hits));
          chk(miss_cnt_o == CNT_W'(it.misses), "R9", "miss counter", 32'(miss_cnt_o), 32'(it.misses));
        end
        saw_mem = 1'b0;
      end
      prev_ready = ready_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin sh_valid[i] = 1'b0; sh_tag[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk(!ready_o, "R1", "ready after reset", 32'(ready_o), 32'd0);
    chk(!mem_req_o, "R1", "mem_req after reset", 32'(mem_req_o), 32'd0);
    chk(hit_cnt_o == 0 && miss_cnt_o == 0, "R1", "counters after reset",
        32'(hit_cnt_o) + 32'(miss_cnt_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R3: invalid line with matching reset tag 0 must miss
    access(1'b0, 5'b00_000, '0);
    access(1'b0, 5'b00_000, '0);      // R4 hit
    access(1'b0, 5'b00_001, '0);      // R5 miss then fill
    access(1'b0, 5'b00_001, '0);      // R4 hit
    access(1'b0, 5'b01_001, '0);      // R7 evicts tag 0
    access(1'b0, 5'b00_001, '0);      // R7 old address misses
    access(1'b1, 5'b10_001, 16'hAAAA); // R6 write miss allocates
    access(1'b0, 5'b10_001, '0);      // R6 read hit of written word
    access(1'b1, 5'b10_001, 16'hBBBB); // R6 write hit goes through
    access(1'b0, 5'b10_001, '0);
    access(1'b0, 5'b00_111, '0);
    access(1'b0, 5'b00_111, '0);
    // R2: sweep every address, each index cycles through all tags
    for (int a = 0; a < WORDS; a++) access(1'b0, ADDR_W'(a), '0);
    for (int a = WORDS - LINES; a < WORDS; a++) access(1'b0, ADDR_W'(a), '0);
    for (int a = 0; a < LINES; a++) access(1'b1, ADDR_W'(a + 2 * LINES), DATA_W'(16'hC000 + a));
    for (int a = 0; a < WORDS; a++) access(1'b0, ADDR_W'(a), '0);
    repeat (4) @(negedge clk_i);
    chk(sb_q.size() == 0, "R8", "all requests completed", 32'(sb_q.size()), 32'd0);
    chk(hit_cnt_o == CNT_W'(exp_hits), "R9", "final hit count", 32'(hit_cnt_o), 32'(exp_hits));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule